// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a clocked system to an external asynchronous static RAM. One request at a time enters on a valid/ready handshake. Each request carries an address, write data and a direction flag. The controller then drives the memory's active-low chip select, write strobe and output-enable strobe, its address lines, and the data pins. The data pins are presented as a drive value, a drive enable and a sampled input, so a pad cell can complete the tri-state buffer. Reads end with the captured byte and a one-cycle completion pulse. Writes end with the same completion pulse.

Every minimum interval of the memory is met by counting clock cycles. The parameters give each interval in picoseconds together with the clock period. The counts come from rounding each interval up to whole cycles. A second parameter selects how a write is terminated. In the default style, the write strobe rises first and ends the write. In the other style, the chip select rises first and ends the write. After a read, the controller waits out the memory's output release time before it will drive the data pins again.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, all three strobes are high (1), the data drive enable is 0, ready is 1 and the completion pulse is 0.
- R2: A request is taken on a rising edge where valid and ready are both 1. Ready stays 0 from that edge until the access, including its recovery, is over.
- R3: A read holds chip select and output enable low and the write strobe high for ACC cycles, starting from the accepting edge. ACC is ceil(max(address access, select access, output-enable access, read cycle) / clock period), which is 9 at 8 ns. The address lines carry the requested address throughout.
- R4: A read samples the data input on the edge that ends the ACC cycles. In the cycle after the last low-strobe cycle, it shows the sampled byte on the read-data port with the completion pulse at 1.
- R5: After a read, the strobes are high and ready stays 0 for REL more cycles. REL is ceil(output release time / clock period), which is 4 at 8 ns. The data drive enable never turns on fewer than REL cycles after output enable rose.
- R6: With the write strobe as terminator (mode 0), a write holds chip select and the write strobe low for PW cycles. PW is ceil(max(write pulse, select-to-end, address-to-end, data setup) / clock period), which is 8 at 8 ns. The write strobe then rises while chip select stays low for TAIL cycles. TAIL is max(1, ceil(write cycle / clock period) - PW), which is 1 at 8 ns.
- R7: With chip select as terminator (mode 1), the same PW cycles are followed by TAIL cycles in which chip select is high and the write strobe is still low.
- R8: A write drives the requested byte on the data output with the drive enable at 1 for all PW+TAIL cycles. In the next cycle all strobes are high, the enable is 0, the completion pulse is 1 and ready is 1.
- R9: Output enable stays high whenever the write strobe is low or the data drive enable is 1.
- R10: Address and write data do not change while any strobe is low.
- R11: The completion pulse lasts exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (19) | Request address |
| req_wdata | input | DW (8) | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW (8) | Byte captured by the last read |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | AW (19) | Memory address lines |
| sram_dq_out | output | DW (8) | Value for the data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | DW (8) | Value sampled from the data pins |

## Verification
A wrong internal state or a miscounted interval shows up at the strobe pins, in the very cycle it occurs. The symptoms are a low phase one cycle too short or too long, the wrong strobe rising first, or output enable low during a write. A capture made on the wrong edge shows one cycle later as a wrong read byte, or as a completion pulse in the wrong cycle. A turnaround that is too short shows on the drive enable as the first cycle of the next write. A handshake fault appears as ready at 1 while a strobe is still low.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACT, ST_RD_REL, ST_WR_PULSE, ST_WR_TAIL
  } asram_state_e;

  // Whole cycles covering an interval (both in picoseconds).
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    return max2(max2(a, b), max2(c, d));
  endfunction

  function automatic int bits_for(input int v);
    int n = 1;
    while ((1 << n) <= v) n++;
    return n;
  endfunction
endpackage

// File: rtl/asram_interval.sv
`timescale 1ns/1ps
module asram_interval #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/asram_strobes.sv
`timescale 1ns/1ps
module asram_strobes
  import asram_pkg::*;
#(
  parameter bit WRITE_BY_CE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  asram_state_e nxt_state,
  output logic         ce_n,
  output logic         we_n,
  output logic         oe_n,
  output logic         dq_oe
);
  logic ce_d, we_d, oe_d, dr_d;
  logic tail_ce, tail_we;

  generate
    if (WRITE_BY_CE) begin : g_ce_term
      assign tail_ce = 1'b0;
      assign tail_we = 1'b1;
    end else begin : g_we_term
      assign tail_ce = 1'b1;
      assign tail_we = 1'b0;
    end
  endgenerate

  always_comb begin
    ce_d = 1'b0; we_d = 1'b0; oe_d = 1'b0; dr_d = 1'b0;
    case (nxt_state)
      ST_RD_ACT:   begin ce_d = 1'b1; oe_d = 1'b1; end
      ST_WR_PULSE: begin ce_d = 1'b1; we_d = 1'b1; dr_d = 1'b1; end
      ST_WR_TAIL:  begin ce_d = tail_ce; we_d = tail_we; dr_d = 1'b1; end
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n <= 1'b1; we_n <= 1'b1; oe_n <= 1'b1; dq_oe <= 1'b0;
    end else begin
      ce_n <= !ce_d; we_n <= !we_d; oe_n <= !oe_d; dq_oe <= dr_d;
    end
  end

  p_oe_high_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || dq_oe) |-> oe_n);
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW          = 19,
  parameter int DW          = 8,
  parameter bit WRITE_BY_CE = 1'b0,
  parameter int CLK_PS      = 8000,
  parameter int T_RC_PS     = 70000,
  parameter int T_AA_PS     = 70000,
  parameter int T_ACE_PS    = 70000,
  parameter int T_DOE_PS    = 35000,
  parameter int T_WC_PS     = 70000,
  parameter int T_SCE_PS    = 60000,
  parameter int T_AW_PS     = 60000,
  parameter int T_PWE_PS    = 50000,
  parameter int T_SD_PS     = 30000,
  parameter int T_HZ_PS     = 25000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  localparam int ACC  = max2(cycles_for(max4(T_AA_PS, T_ACE_PS, T_DOE_PS, 0), CLK_PS),
                             cycles_for(T_RC_PS, CLK_PS));
  localparam int PW   = max2(1, cycles_for(max4(T_PWE_PS, T_SCE_PS, T_AW_PS, T_SD_PS), CLK_PS));
  localparam int TAIL = max2(1, cycles_for(T_WC_PS, CLK_PS) - PW);
  localparam int REL  = max2(1, cycles_for(T_HZ_PS, CLK_PS));
  localparam int CW   = bits_for(max4(ACC, PW, TAIL, REL));

  asram_state_e  state, nxt_state;
  logic          accept, ld, expired, rd_cap, wr_fin;
  logic [CW-1:0] ld_val;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt_state = state;
    ld = 1'b0; ld_val = '0; rd_cap = 1'b0; wr_fin = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        ld = 1'b1;
        if (req_write) begin nxt_state = ST_WR_PULSE; ld_val = CW'(PW - 1);  end
        else           begin nxt_state = ST_RD_ACT;   ld_val = CW'(ACC - 1); end
      end
      ST_RD_ACT: if (expired) begin
        nxt_state = ST_RD_REL; ld = 1'b1; ld_val = CW'(REL - 1); rd_cap = 1'b1;
      end
      ST_RD_REL: if (expired) nxt_state = ST_IDLE;
      ST_WR_PULSE: if (expired) begin
        nxt_state = ST_WR_TAIL; ld = 1'b1; ld_val = CW'(TAIL - 1);
      end
      ST_WR_TAIL: if (expired) begin nxt_state = ST_IDLE; wr_fin = 1'b1; end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; rsp_done <= 1'b0; rsp_rdata <= '0;
      sram_addr <= '0; sram_dq_out <= '0;
    end else begin
      state    <= nxt_state;
      rsp_done <= rd_cap || wr_fin;
      if (rd_cap) rsp_rdata <= sram_dq_in;
      if (accept) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
    end
  end

  asram_interval #(.CW(CW)) i_interval (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expired(expired)
  );

  asram_strobes #(.WRITE_BY_CE(WRITE_BY_CE)) i_strobes (
    .clk(clk), .rst_n(rst_n), .nxt_state(nxt_state),
    .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n), .dq_oe(sram_dq_oe)
  );

  // Assertion support: cycles since output enable went high, and the length of the write overlap.
  logic [CW-1:0] oe_hi_cnt, wr_low_cnt;
  logic          wr_overlap;
  assign wr_overlap = !sram_ce_n && !sram_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= CW'(REL); wr_low_cnt <= '0;
    end else begin
      if (!sram_oe_n) oe_hi_cnt <= '0;
      else if (oe_hi_cnt < CW'(REL)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
      if (!wr_overlap) wr_low_cnt <= '0;
      else if (wr_low_cnt < CW'(PW)) wr_low_cnt <= wr_low_cnt + 1'b1;
    end
  end

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_hi_cnt >= CW'(REL)));
  p_write_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_overlap && $past(wr_overlap)) |-> (wr_low_cnt >= CW'(PW)));
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n || !sram_we_n || !sram_oe_n) |-> !req_ready);
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((!sram_ce_n || !sram_we_n) && $past(!sram_ce_n || !sram_we_n)) |->
      ($stable(sram_addr) && $stable(sram_dq_out)));
  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
endmodule

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;
  localparam int AW = 19, DW = 8, CLK_PS = 8000;

  function automatic int b_ceil(input int t, input int p);
    int n = 0;
    while (n * p < t) n++;
    return n;
  endfunction
  function automatic int b_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R3, R5, R6 counts restated from the requirements
  localparam int E_ACC  = b_max(b_ceil(70000, CLK_PS), b_ceil(35000, CLK_PS));
  localparam int E_PW   = b_max(b_max(b_ceil(50000, CLK_PS), b_ceil(60000, CLK_PS)), b_ceil(30000, CLK_PS));
  localparam int E_TAIL = b_max(1, b_ceil(70000, CLK_PS) - E_PW);
  localparam int E_REL  = b_max(1, b_ceil(25000, CLK_PS));

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic rdy_w, done_w, ce_w, we_w, oe_w, dqoe_w;
  logic rdy_c, done_c, ce_c, we_c, oe_c, dqoe_c;
  logic [DW-1:0] rd_w, rd_c, dqo_w, dqo_c, dqi_w, dqi_c;
  logic [AW-1:0] ad_w, ad_c;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_mem [256];

  always #4 clk = !clk;

  asram_ctrl #(.WRITE_BY_CE(1'b0)) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_w),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(done_w), .rsp_rdata(rd_w), .sram_ce_n(ce_w), .sram_we_n(we_w),
    .sram_oe_n(oe_w), .sram_addr(ad_w), .sram_dq_out(dqo_w), .sram_dq_oe(dqoe_w),
    .sram_dq_in(dqi_w));

  asram_ctrl #(.WRITE_BY_CE(1'b1)) i_asram_ctrl_ce (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_c),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(done_c), .rsp_rdata(rd_c), .sram_ce_n(ce_c), .sram_we_n(we_c),
    .sram_oe_n(oe_c), .sram_addr(ad_c), .sram_dq_out(dqo_c), .sram_dq_oe(dqoe_c),
    .sram_dq_in(dqi_c));

  // Memory model: stores while select and write strobe are both low; drives when selected with OE low.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (!ce_w && !we_w) begin
      mem[ad_w[7:0]] <= dqo_w;
    end
  end
  assign dqi_w = (!ce_w && !oe_w) ? mem[ad_w[7:0]] : 8'h00;
  assign dqi_c = (!ce_c && !oe_c) ? mem[ad_c[7:0]] : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    @(negedge clk);
    while (!rdy_w) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    n = wr ? (E_PW + E_TAIL + 1) : (E_ACC + E_REL + 1);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (!wr) begin
        if (k <= E_ACC) begin
          check(!ce_w && !oe_w && we_w && !dqoe_w && !ce_c && !oe_c && we_c,
                "R3 read strobes", {ce_w, we_w, oe_w}, 3'b010);
          check(ad_w == a && ad_c == a, "R3 read address", int'(ad_w), int'(a));
          check(!rdy_w && !rdy_c, "R2 ready low while busy", rdy_w, 0);
        end else if (k == E_ACC + 1) begin
          check(done_w && done_c, "R4 done after read", done_w, 1);
          check(rd_w == exp_mem[a[7:0]] && rd_c == exp_mem[a[7:0]], "R4 read data",
                int'(rd_w), int'(exp_mem[a[7:0]]));
          check(ce_w && oe_w && we_w && !rdy_w, "R5 release strobes high",
                {ce_w, we_w, oe_w, rdy_w}, 4'b1110);
        end else if (k < n) begin
          check(!rdy_w && !rdy_c && !done_w && ce_w && oe_w, "R5 turnaround hold",
                {rdy_w, done_w}, 0);
        end else begin
          check(rdy_w && rdy_c && !done_w, "R5 ready after release", rdy_w, 1);
        end
      end else begin
        if (k <= E_PW) begin
          check(!ce_w && !we_w && oe_w && !ce_c && !we_c && oe_c, "R6 write pulse strobes",
                {ce_w, we_w, oe_w}, 3'b001);
          check(dqoe_w && dqo_w == d && dqoe_c && dqo_c == d, "R8 write data driven",
                int'(dqo_w), int'(d));
          check(oe_w && oe_c, "R9 oe high in write", oe_w, 1);
          check(!rdy_w, "R2 ready low while busy", rdy_w, 0);
        end else if (k <= E_PW + E_TAIL) begin
          check(!ce_w && we_w && dqoe_w && dqo_w == d, "R6 write strobe ends first",
                {ce_w, we_w, dqoe_w}, 3'b011);
          check(ce_c && !we_c && dqoe_c && dqo_c == d, "R7 select ends first",
                {ce_c, we_c, dqoe_c}, 3'b101);
          check(ad_w == a && ad_c == a, "R10 address held", int'(ad_w), int'(a));
        end else begin
          check(ce_w && we_w && oe_w && !dqoe_w && ce_c && we_c && !dqoe_c,
                "R8 idle after write", {ce_w, we_w, oe_w, dqoe_w}, 4'b1110);
          check(done_w && done_c && rdy_w && rdy_c, "R8 done and ready",
                {done_w, rdy_w}, 2'b11);
        end
      end
      if (k == 1) req_valid = 1'b0;
    end
    @(negedge clk);
    check(!done_w && !done_c, "R11 done is one cycle", done_w, 0);
    if (wr) exp_mem[a[7:0]] = d;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    check(ce_w && we_w && oe_w && !dqoe_w && rdy_w && !done_w, "R1 reset state",
          {ce_w, we_w, oe_w, dqoe_w, rdy_w, done_w}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_c && we_c && oe_c && !dqoe_c && rdy_c && !done_c, "R1 idle after reset",
          {ce_c, we_c, oe_c, dqoe_c}, 4'b1110);
    // R2: valid held low, nothing starts
    repeat (3) @(negedge clk);
    check(ce_w && oe_w && we_w && rdy_w, "R2 no request no access", {ce_w, rdy_w}, 2'b11);
    // Directed corners
    do_op(1'b0, 19'h00012, 8'h00);          // unwritten cell
    do_op(1'b1, 19'h00012, 8'hA5);          // write right after read (turnaround)
    do_op(1'b0, 19'h00012, 8'h00);          // read back
    do_op(1'b1, 19'h7FFFF, 8'hFF);          // top address
    do_op(1'b1, 19'h000FF, 8'h00);
    do_op(1'b0, 19'h7FFFF, 8'h00);
    // Constrained random mix
    void'($urandom(32'd1234));
    for (int t = 0; t < 40; t++) begin
      logic [AW-1:0] a;
      a = {$urandom_range(2047, 0)} << 8 | 19'($urandom_range(15, 0));
      do_op(1'($urandom_range(1, 0)), a, 8'($urandom_range(255, 0)));
    end
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule